// File: doc/BRIEF.md
# Time-Calendar Counter with Alarm Compare

This block holds the running time and date: seconds, minutes, hours, day of week, day of month, month and two-digit year. A one-cycle pulse on `tick_1hz` advances the whole set by one second in a single clock cycle, so a read through the register port never sees half-updated fields. All time, calendar and alarm bytes share one encoding, packed BCD or plain binary, and hours are kept in either a 24-hour or a 12-hour form, chosen in the control byte.

Software reaches the block through a simple synchronous register port. To load a new time it sets the hold bit, writes the fields, then clears hold. A tick that lands in the same cycle as a register write is kept pending and applied in the first following cycle without a write. After every applied step the block raises `update_done` for one cycle. In that same cycle it raises `alarm_hit` if the new seconds, minutes and hours agree with the three alarm bytes, so that an interrupt block can consume both pulses.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset the registers read: seconds, minutes, hours and year 0x00, day of week, date and month 0x01, the three alarm bytes 0x00, and control 0x02 (24-hour, BCD, running).
- R2: Register addresses are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 alarm seconds, 8 alarm minutes, 9 alarm hours, 10 control. Control bit 7 is hold, bit 2 selects binary (1) or BCD (0), and bit 1 selects 24-hour (1) or 12-hour (0). A write stores `wr_data` at the clock edge. `rd_data` shows the addressed byte combinationally, and unused addresses read 0x00.
- R3: In BCD mode (high nibble tens, low nibble units) seconds and minutes wrap 59 to 0 with carry, and 24-hour hours wrap 23 to 0 with carry into the day.
- R4: In binary mode every field holds its plain binary value and carries at the same limits as in BCD.
- R5: In 12-hour mode the hours byte holds 1 to 12 in bits 6:0, and bit 7 is 1 for PM. The count runs 12, 1, 2 … 11. Going from 11 to 12 toggles bit 7, and 11 PM to 12 AM advances the day.
- R6: Day of week counts 1 to 7, wraps 7 to 1, and advances only when the day rolls over.
- R7: Date wraps to 1 after day 30 in months 4, 6, 9 and 11, after day 31 in the other months, and after day 29 in February when the year is divisible by 4, otherwise after day 28.
- R8: Month wraps 12 to 1 and advances the year, and year wraps 99 to 0.
- R9: While hold is 1, ticks are discarded and no field changes except by register writes. After hold is cleared, each later tick steps exactly one second.
- R10: A tick that arrives in a cycle with `wr_en` high is applied in the first following cycle with `wr_en` low, and `update_done` stays low until then.
- R11: `alarm_hit` pulses together with `update_done` when each of the new seconds, minutes and hours equals its alarm byte, or that alarm byte has bits 7:6 both 1 (don't care).
- R12: `update_done` is high for exactly one cycle after each applied step, and its register changes are visible in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1hz | input | 1 | One-cycle pulse requesting a one-second step |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Addressed register contents |
| update_done | output | 1 | One-cycle pulse after each applied step |
| alarm_hit | output | 1 | One-cycle pulse when the stepped time matches the alarm |

## Verification
A corrupted field or a wrong carry shows up at `rd_data` in the same cycle as the `update_done` pulse for the step that caused it. The bench reads all seven fields back after every tick. A wrong month length or leap rule stays hidden until a month-end step, and a wrong year wrap until the end of year 99. Directed month-end, year-end and 11/12 o'clock cases therefore sit next to random loads biased toward wrap values. A lost or duplicated pending tick shows as a missing or extra `update_done` pulse in the cycle after a collision, and as a seconds value off by one.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int N_ALARM = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t year;
    byte_t mon;
    byte_t date;
    byte_t dow;
    byte_t hour;
    byte_t min;
    byte_t sec;
  } tcal_t;

  localparam logic [ADDR_W-1:0] A_SEC   = 4'd0;
  localparam logic [ADDR_W-1:0] A_MIN   = 4'd1;
  localparam logic [ADDR_W-1:0] A_HOUR  = 4'd2;
  localparam logic [ADDR_W-1:0] A_DOW   = 4'd3;
  localparam logic [ADDR_W-1:0] A_DATE  = 4'd4;
  localparam logic [ADDR_W-1:0] A_MON   = 4'd5;
  localparam logic [ADDR_W-1:0] A_YEAR  = 4'd6;
  localparam logic [ADDR_W-1:0] A_ALM0  = 4'd7;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd10;

  localparam int CTL_HOLD = 7;
  localparam int CTL_BIN  = 2;
  localparam int CTL_H24  = 1;

  // field byte -> plain count
  function automatic logic [6:0] dec(input byte_t v, input logic bin);
    logic [6:0] r;
    if (bin) r = v[6:0];
    else     r = 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    return r;
  endfunction

  // plain count -> field byte
  function automatic byte_t enc(input logic [6:0] n, input logic bin);
    byte_t r;
    if (bin) r = {1'b0, n};
    else begin
      r[7:4] = 4'(n / 7'd10);
      r[3:0] = 4'(n % 7'd10);
    end
    return r;
  endfunction

  function automatic logic [6:0] month_len(input logic [6:0] mo, input logic [6:0] yr);
    logic [6:0] r;
    case (mo)
      7'd4, 7'd6, 7'd9, 7'd11: r = 7'd30;
      7'd2:                    r = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      default:                 r = 7'd31;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_pkg::*;
(
  input  tcal_t cur,
  input  logic  bin,
  input  logic  h24,
  output tcal_t nxt
);
  logic [6:0] s, m, h, d, mo, y, w, h12;
  logic [6:0] ns, nm, nh, nd, nmo, ny, nw, hp;
  byte_t      hb;

  always_comb begin
    s   = dec(cur.sec, bin);
    m   = dec(cur.min, bin);
    d   = dec(cur.date, bin);
    mo  = dec(cur.mon, bin);
    y   = dec(cur.year, bin);
    w   = dec(cur.dow, bin);
    h12 = dec({1'b0, cur.hour[6:0]}, bin);
    // work internally on a 0..23 hour count
    if (h24) h = dec(cur.hour, bin);
    else     h = ((h12 == 7'd12) ? 7'd0 : h12) + (cur.hour[7] ? 7'd12 : 7'd0);

    ns = s + 7'd1; nm = m; nh = h; nd = d; nmo = mo; ny = y; nw = w;
    if (s >= 7'd59) begin
      ns = 7'd0;
      nm = m + 7'd1;
      if (m >= 7'd59) begin
        nm = 7'd0;
        nh = h + 7'd1;
        if (h >= 7'd23) begin
          nh = 7'd0;
          nw = (w >= 7'd7) ? 7'd1 : w + 7'd1;
          nd = d + 7'd1;
          if (d >= month_len(mo, y)) begin
            nd  = 7'd1;
            nmo = mo + 7'd1;
            if (mo >= 7'd12) begin
              nmo = 7'd1;
              ny  = (y >= 7'd99) ? 7'd0 : y + 7'd1;
            end
          end
        end
      end
    end

    hp = (nh >= 7'd12) ? nh - 7'd12 : nh;
    if (hp == 7'd0) hp = 7'd12;
    hb = enc(hp, bin);

    nxt.sec  = enc(ns, bin);
    nxt.min  = enc(nm, bin);
    nxt.hour = h24 ? enc(nh, bin) : {(nh >= 7'd12), hb[6:0]};
    nxt.dow  = enc(nw, bin);
    nxt.date = enc(nd, bin);
    nxt.mon  = enc(nmo, bin);
    nxt.year = enc(ny, bin);
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int N_BYTES = 3,
  parameter int W       = 8
) (
  input  logic [N_BYTES-1:0][W-1:0] target,
  input  logic [N_BYTES-1:0][W-1:0] alarm,
  output logic                      hit
);
  logic [N_BYTES-1:0] byte_ok;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_cmp
    assign byte_ok[i] = (alarm[i][W-1:W-2] == 2'b11) || (alarm[i] == target[i]);
  end

  assign hit = &byte_ok;
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  output logic              update_done,
  output logic              alarm_hit
);
  localparam tcal_t TM_RST = '{year: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h01,
                               hour: 8'h00, min: 8'h00, sec: 8'h00};
  localparam byte_t CTL_RST = 8'h02;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  tcal_t                      tm_q, tm_d, tm_nx;
  logic [N_ALARM-1:0][BYTE_W-1:0] alm_q, alm_d;
  byte_t                      ctl_q, ctl_d;
  logic                       pend_q, pend_d, upd_q, upd_d, hit_q, hit_d;
  logic                       go, match;

  rtc_cal_step u_step (
    .cur (tm_q),
    .bin (ctl_q[CTL_BIN]),
    .h24 (ctl_q[CTL_H24]),
    .nxt (tm_nx)
  );

  rtc_alarm_cmp #(.N_BYTES(N_ALARM), .W(BYTE_W)) u_alarm (
    .target ({tm_nx.hour, tm_nx.min, tm_nx.sec}),
    .alarm  (alm_q),
    .hit    (match)
  );

  // next state
  always_comb begin
    tm_d   = tm_q;
    alm_d  = alm_q;
    ctl_d  = ctl_q;
    go     = (tick_1hz | pend_q) & ~wr_en & ~ctl_q[CTL_HOLD];
    pend_d = (tick_1hz | pend_q) &  wr_en & ~ctl_q[CTL_HOLD];
    if (go) tm_d = tm_nx;
    if (wr_en) begin
      case (addr)
        A_SEC:   tm_d.sec  = wr_data;
        A_MIN:   tm_d.min  = wr_data;
        A_HOUR:  tm_d.hour = wr_data;
        A_DOW:   tm_d.dow  = wr_data;
        A_DATE:  tm_d.date = wr_data;
        A_MON:   tm_d.mon  = wr_data;
        A_YEAR:  tm_d.year = wr_data;
        A_CTRL:  ctl_d     = wr_data;
        default: ;
      endcase
      for (int i = 0; i < N_ALARM; i++)
        if (addr == ADDR_W'(int'(A_ALM0) + i)) alm_d[i] = wr_data;
    end
    upd_d = go;
    hit_d = go & match;
  end

  // registers
  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      tm_q   <= TM_RST;
      alm_q  <= '0;
      ctl_q  <= CTL_RST;
      pend_q <= 1'b0;
      upd_q  <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      tm_q   <= tm_d;
      alm_q  <= alm_d;
      ctl_q  <= ctl_d;
      pend_q <= pend_d;
      upd_q  <= upd_d;
      hit_q  <= hit_d;
    end
  end

  // read port
  always_comb begin
    rd_data = '0;
    case (addr)
      A_SEC:   rd_data = tm_q.sec;
      A_MIN:   rd_data = tm_q.min;
      A_HOUR:  rd_data = tm_q.hour;
      A_DOW:   rd_data = tm_q.dow;
      A_DATE:  rd_data = tm_q.date;
      A_MON:   rd_data = tm_q.mon;
      A_YEAR:  rd_data = tm_q.year;
      A_CTRL:  rd_data = ctl_q;
      default: ;
    endcase
    for (int i = 0; i < N_ALARM; i++)
      if (addr == ADDR_W'(int'(A_ALM0) + i)) rd_data = alm_q[i];
  end

  assign update_done = upd_q;
  assign alarm_hit   = hit_q;

  // R9: no time change while held and not written
  assert_hold_freeze_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (ctl_q[CTL_HOLD] && !wr_en) |=> $stable(tm_q));

  // R11: an alarm pulse only comes with an update pulse
  assert_alarm_with_update_R11: assert property (@(posedge clk) disable iff (!srst_n)
    alarm_hit |-> update_done);

  // R6: weekday stays in 1..7 after a step
  assert_dow_range_R6: assert property (@(posedge clk) disable iff (!srst_n)
    update_done |-> (tm_q.dow >= 8'd1 && tm_q.dow <= 8'd7));

  // R3: seconds are legal after a step
  assert_sec_legal_R3: assert property (@(posedge clk) disable iff (!srst_n)
    update_done |-> (dec(tm_q.sec, ctl_q[CTL_BIN]) < 7'd60));

  // R10: a pending step is taken on the first free cycle
  assert_pend_taken_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (pend_q && !wr_en && !ctl_q[CTL_HOLD]) |=> update_done);
endmodule

// File: tb/rtc_timekeeper_test.sv
module rtc_timekeeper_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1hz;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       update_done;
  logic       alarm_hit;

  int checks = 0;
  int failures = 0;
  int T[7];          // sec, min, hour(0..23), dow, date, month, year
  int AL[3];
  logic mbin, mh24;

  always #4 clk = ~clk;   // 125 MHz

  rtc_timekeeper uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .update_done(update_done), .alarm_hit(alarm_hit)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int enc(input int n, input logic b);
    return b ? n : (((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int enc_hour(input int h, input logic b, input logic t24);
    int hp;
    if (t24) return enc(h, b);
    hp = h % 12;
    if (hp == 0) hp = 12;
    return ((h >= 12) ? 128 : 0) | enc(hp, b);
  endfunction

  function automatic int exp_byte(input int i);
    return (i == 2) ? enc_hour(T[2], mbin, mh24) : enc(T[i], mbin);
  endfunction

  function automatic int mdays(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_step();
    T[0]++;
    if (T[0] == 60) begin
      T[0] = 0; T[1]++;
      if (T[1] == 60) begin
        T[1] = 0; T[2]++;
        if (T[2] == 24) begin
          T[2] = 0;
          T[3] = (T[3] == 7) ? 1 : T[3] + 1;
          T[4]++;
          if (T[4] > mdays(T[5], T[6])) begin
            T[4] = 1; T[5]++;
            if (T[5] == 13) begin T[5] = 1; T[6] = (T[6] == 99) ? 0 : T[6] + 1; end
          end
        end
      end
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic check_time(input string tag);
    int v;
    for (int i = 0; i < 7; i++) begin
      rd(i, v);
      chk(tag, v, exp_byte(i));
    end
  endtask

  function automatic int ctl_byte(input logic hold);
    return (hold ? 128 : 0) | (mbin ? 4 : 0) | (mh24 ? 2 : 0);
  endfunction

  task automatic load(input int s, input int m, input int h, input int dw,
                      input int d, input int mo, input int y);
    T[0] = s; T[1] = m; T[2] = h; T[3] = dw; T[4] = d; T[5] = mo; T[6] = y;
    wr(10, ctl_byte(1'b1));
    for (int i = 0; i < 7; i++) wr(i, exp_byte(i));
    for (int i = 0; i < 3; i++) wr(7 + i, AL[i]);
    wr(10, ctl_byte(1'b0));
  endtask

  // step once, then check update pulse, optional alarm, and all fields
  task automatic tick_check(input string tag, input int exp_hit);
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    model_step();
    chk({tag, " R12 update pulse"}, int'(update_done), 1);
    if (exp_hit >= 0) chk({tag, " R11 alarm"}, int'(alarm_hit), exp_hit);
    @(negedge clk);
    chk({tag, " R12 single cycle"}, int'(update_done), 0);
    check_time(tag);
  endtask

  initial begin
    #1_600_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v, seed, ehit;
    tick_1hz = 0; wr_en = 0; addr = 0; wr_data = 0; rst_n = 0;
    AL[0] = 8'hC0; AL[1] = 8'hC0; AL[2] = 8'hC0;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset values
    mbin = 0; mh24 = 1;
    T[0] = 0; T[1] = 0; T[2] = 0; T[3] = 1; T[4] = 1; T[5] = 1; T[6] = 0;
    check_time("R1 reset time");
    for (int i = 7; i < 10; i++) begin rd(i, v); chk("R1 reset alarm", v, 0); end
    rd(10, v); chk("R1 reset control", v, 8'h02);
    chk("R1 reset update_done", int'(update_done), 0);

    // R2 register write and readback
    wr(7, 8'h5A); wr(8, 8'hA5); wr(9, 8'h3C);
    rd(7, v); chk("R2 alarm0", v, 8'h5A);
    rd(8, v); chk("R2 alarm1", v, 8'hA5);
    rd(9, v); chk("R2 alarm2", v, 8'h3C);
    rd(12, v); chk("R2 unused address", v, 0);
    wr(10, 8'h86); rd(10, v); chk("R2 control", v, 8'h86);
    AL[0] = 8'hC0; AL[1] = 8'hC0; AL[2] = 8'hC0;

    // R3 R6 R8: BCD year-end rollover, weekday 7 -> 1
    mbin = 0; mh24 = 1;
    load(59, 59, 23, 7, 31, 12, 99);
    tick_check("R3 R6 R8 BCD year end", 1);
    // R7 leap and short months
    load(59, 59, 23, 3, 28, 2, 24); tick_check("R7 leap feb28", 1);
    load(59, 59, 23, 4, 29, 2, 24); tick_check("R7 leap feb29", 1);
    load(59, 59, 23, 4, 28, 2, 23); tick_check("R7 nonleap feb28", 1);
    load(59, 59, 23, 5, 30, 4, 10); tick_check("R7 april 30", 1);
    load(59, 59, 23, 5, 30, 5, 10); tick_check("R7 may 30", 1);
    // R4 binary mode
    mbin = 1;
    load(59, 59, 23, 6, 31, 12, 99); tick_check("R4 binary year end", 1);
    load(59, 59, 9, 2, 15, 6, 45);   tick_check("R4 binary hour carry", 1);
    // R5 12-hour transitions
    mh24 = 0;
    load(59, 59, 11, 2, 10, 3, 5);  tick_check("R5 11AM to 12PM", 1);
    load(59, 59, 12, 2, 10, 3, 5);  tick_check("R5 12PM to 1PM", 1);
    mbin = 0;
    load(59, 59, 23, 7, 31, 1, 5);  tick_check("R5 11PM to 12AM day", 1);
    load(59, 59, 0, 1, 1, 2, 5);    tick_check("R5 12AM to 1AM", 1);

    // R9 hold drops ticks
    mbin = 0; mh24 = 1;
    load(10, 20, 5, 3, 14, 7, 31);
    wr(10, ctl_byte(1'b1));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); tick_1hz = 1;
      @(negedge clk); tick_1hz = 0;
      chk("R9 no update while held", int'(update_done), 0);
    end
    check_time("R9 held time");
    wr(10, ctl_byte(1'b0));
    tick_check("R9 resume single step", -1);

    // R10 tick colliding with a write
    @(negedge clk);
    tick_1hz = 1; wr_en = 1; addr = 4'd7; wr_data = 8'hC1;
    @(negedge clk);
    tick_1hz = 0; wr_en = 0; addr = 4'd0;
    #1 chk("R10 no update in write cycle", int'(update_done), 0);
    chk("R10 seconds unchanged", int'(rd_data), exp_byte(0));
    @(negedge clk);
    model_step();
    chk("R10 deferred update", int'(update_done), 1);
    @(negedge clk);
    chk("R10 single deferred step", int'(update_done), 0);
    check_time("R10 after deferred step");

    // R11 alarm: exact, don't-care, mismatch
    mbin = 0; mh24 = 1;
    AL[0] = enc(0, 0); AL[1] = enc(31, 0); AL[2] = enc(8, 0);
    load(59, 30, 8, 1, 1, 1, 1); tick_check("R11 exact match", 1);
    AL[0] = 8'h01;
    load(59, 30, 8, 1, 1, 1, 1); tick_check("R11 mismatch", 0);
    AL[0] = 8'hC0; AL[1] = 8'hFF; AL[2] = enc(8, 0);
    load(59, 30, 8, 1, 1, 1, 1); tick_check("R11 dont care", 1);

    // random mix of modes and values biased toward wraps
    for (int it = 0; it < 250; it++) begin
      int s, m, h, dw, d, mo, y, md;
      int nx[3];
      mbin = 1'($urandom % 2);
      mh24 = 1'($urandom % 2);
      s  = ($urandom % 3 == 0) ? 59 : $urandom % 60;
      m  = ($urandom % 3 == 0) ? 59 : $urandom % 60;
      case ($urandom % 4)
        0: h = 23;
        1: h = 11;
        default: h = $urandom % 24;
      endcase
      mo = 1 + $urandom % 12;
      y  = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      md = mdays(mo, y);
      d  = ($urandom % 2 == 0) ? md : 1 + $urandom % md;
      dw = 1 + $urandom % 7;
      // predict next seconds, minutes, hour bytes
      T[0] = s; T[1] = m; T[2] = h; T[3] = dw; T[4] = d; T[5] = mo; T[6] = y;
      model_step();
      nx[0] = exp_byte(0); nx[1] = exp_byte(1); nx[2] = exp_byte(2);
      ehit = 1;
      for (int i = 0; i < 3; i++) begin
        case ($urandom % 3)
          0: AL[i] = 8'hC0 | ($urandom % 64);
          1: AL[i] = nx[i];
          default: AL[i] = $urandom % 256;
        endcase
        if (!((AL[i] >> 6) == 3 || AL[i] == nx[i])) ehit = 0;
      end
      load(s, m, h, dw, d, mo, y);
      tick_check("R3 R4 R5 R7 R11 random", ehit);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule